// File: doc/BRIEF.md
# Split-Table Function ROM

This block is a read-only function table. It takes an `ADDR_W`-bit address and returns the `RES_W`-bit entry of a fixed smooth function. It does not store one full-width table. It keeps two smaller ones.

- **Base table.** It has one row per slice of `2^SLICE_BITS` consecutive addresses and gives a high-order base value of `HI_W` bits.
- **Delta table.** It has one row per address and gives a narrow correction of `LO_W` bits.

The result is rebuilt by shifting the base left by `RES_W−HI_W` and adding the delta. This is exact for every address. The two parts overlap by `HI_W+LO_W−RES_W` bits. In the default geometry that is 2 bits, and 992 bits are stored instead of 2048.

Both tables are computed at elaboration from the same reference function, so no contents are loaded at run time. The block has no state machine. Its only sequential element is the optional output register. With `REG_OUT=1` the result appears one clock after the address. With `REG_OUT=0` the block is purely combinational.

Top module: `ldt_rom`

## Requirements
- R1: The entry for address a is N/4 + floor(a·(3N−a)/(4N)) modulo 2^RES_W, with N = 2^ADDR_W. The base table is indexed by the upper ADDR_W−SLICE_BITS address bits. Each base row holds the minimum of its slice with the low RES_W−HI_W bits cleared, so a row never exceeds any entry of its slice.
- R2: The delta table is indexed by the full address and is LO_W bits wide. Every difference between an entry and its scaled base fits in LO_W bits, and this is checked at elaboration.
- R3: For every address, the rebuilt value equals the entry defined in R1 (lossless).
- R4: The lowest RES_W−HI_W result bits come straight from the delta value, and only HI_W bits pass through the adder. The sum never carries out of RES_W bits. With default parameters every result lies in 64..191.
- R5: With REG_OUT=1, the result shows the entry of the address present at the previous rising clock edge. Before that edge it still shows the earlier value, and it stays constant while the address is held.
- R6: With REG_OUT=1, a synchronous active-high reset clears the result to 0 at the next rising edge.
- R7: With REG_OUT=0, the result follows the address within the same cycle, and reset has no effect on it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| addr | input | ADDR_W | Table address |
| result | output | RES_W | Reconstructed table entry |

## Verification
The bench visits every slice boundary, where the base row changes and a wrong slice index or shift would return a neighbour's base. It sweeps every address against an independently computed table, which catches a truncated delta or a dropped carry; a design with either fault would return values off by a power of two. It also looks at the registered output just before and just after the capturing edge, so a lost or extra pipeline stage shows as a stale value. Finally, it pulses reset in mid-run to confirm that only the registered variant clears.

// File: rtl/ldt_pkg.sv
package ldt_pkg;

    // Reference function: base offset plus a gently curving term (slope below 3/4).
    function automatic int unsigned ldt_ref(int unsigned a, int unsigned addr_w,
                                            int unsigned res_w);
        longint unsigned n;
        longint unsigned v;
        n = longint'(1) << addr_w;
        v = n / 4 + (longint'(a) * (3 * n - longint'(a))) / (4 * n);
        return int'(v & ((longint'(1) << res_w) - 1));
    endfunction

    // Base row for slice b: slice minimum with the pass-through bits dropped.
    function automatic int unsigned ldt_base(int unsigned b, int unsigned addr_w,
                                             int unsigned res_w, int unsigned slice_bits,
                                             int unsigned hi_w);
        int unsigned lo_val;
        int unsigned cur;
        lo_val = ldt_ref(b << slice_bits, addr_w, res_w);
        for (int unsigned j = 1; j < (1 << slice_bits); j++) begin
            cur = ldt_ref((b << slice_bits) + j, addr_w, res_w);
            if (cur < lo_val) lo_val = cur;
        end
        return lo_val >> (res_w - hi_w);
    endfunction

    // Full-width difference between an entry and its scaled base row.
    function automatic int unsigned ldt_delta(int unsigned a, int unsigned addr_w,
                                              int unsigned res_w, int unsigned slice_bits,
                                              int unsigned hi_w);
        int unsigned base;
        base = ldt_base(a >> slice_bits, addr_w, res_w, slice_bits, hi_w);
        return ldt_ref(a, addr_w, res_w) - (base << (res_w - hi_w));
    endfunction

endpackage

// File: rtl/ldt_base_rom.sv
module ldt_base_rom #(
    parameter int ADDR_W     = 8,
    parameter int RES_W      = 8,
    parameter int SLICE_BITS = 3,
    parameter int HI_W       = 7
) (
    input  logic [ADDR_W-SLICE_BITS-1:0] slice_idx,
    output logic [HI_W-1:0]              base
);
    localparam int ROWS = 1 << (ADDR_W - SLICE_BITS);

    logic [HI_W-1:0] rows [ROWS];

    for (genvar i = 0; i < ROWS; i++) begin : g_row
        assign rows[i] = HI_W'(ldt_pkg::ldt_base(i, ADDR_W, RES_W, SLICE_BITS, HI_W));
    end

    assign base = rows[slice_idx];
endmodule

// File: rtl/ldt_delta_rom.sv
module ldt_delta_rom #(
    parameter int ADDR_W     = 8,
    parameter int RES_W      = 8,
    parameter int SLICE_BITS = 3,
    parameter int HI_W       = 7,
    parameter int LO_W       = 3
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [LO_W-1:0]   delta
);
    localparam int ROWS = 1 << ADDR_W;

    logic [LO_W-1:0] rows [ROWS];

    for (genvar i = 0; i < ROWS; i++) begin : g_row
        assign rows[i] = LO_W'(ldt_pkg::ldt_delta(i, ADDR_W, RES_W, SLICE_BITS, HI_W));
    end

    assign delta = rows[addr];

    // R2: every stored difference must fit the narrow width
    initial begin
        for (int i = 0; i < ROWS; i++) begin
            p_delta_fits_r2: assert (ldt_pkg::ldt_delta(i, ADDR_W, RES_W, SLICE_BITS, HI_W)
                                     < (1 << LO_W))
                else $error("delta row %0d exceeds %0d bits", i, LO_W);
        end
    end
endmodule

// File: rtl/ldt_merge.sv
module ldt_merge #(
    parameter int RES_W = 8,
    parameter int HI_W  = 7,
    parameter int LO_W  = 3
) (
    input  logic [HI_W-1:0]  base,
    input  logic [LO_W-1:0]  delta,
    output logic [RES_W-1:0] value,
    output logic             carry
);
    localparam int PASS_W = RES_W - HI_W;

    logic [HI_W:0] upper;

    // Only the overlapping delta bits enter the HI_W-bit adder.
    assign upper = {1'b0, base} + (HI_W + 1)'(delta >> PASS_W);
    assign carry = upper[HI_W];

    if (PASS_W > 0) begin : g_pass
        assign value = {upper[HI_W-1:0], delta[PASS_W-1:0]};
    end else begin : g_nopass
        assign value = upper[HI_W-1:0];
    end
endmodule

// File: rtl/ldt_rom.sv
module ldt_rom #(
    parameter int ADDR_W     = 8,
    parameter int RES_W      = 8,
    parameter int SLICE_BITS = 3,
    parameter int HI_W       = 7,
    parameter int LO_W       = 3,
    parameter bit REG_OUT    = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    output logic [RES_W-1:0]  result
);
    localparam int IDX_W  = ADDR_W - SLICE_BITS;
    localparam int PASS_W = RES_W - HI_W;

    logic [HI_W-1:0]  base;
    logic [LO_W-1:0]  delta;
    logic [RES_W-1:0] merged;
    logic             carry;

    ldt_base_rom #(
        .ADDR_W(ADDR_W), .RES_W(RES_W), .SLICE_BITS(SLICE_BITS), .HI_W(HI_W)
    ) u_base (
        .slice_idx(addr[ADDR_W-1:SLICE_BITS]),
        .base     (base)
    );

    ldt_delta_rom #(
        .ADDR_W(ADDR_W), .RES_W(RES_W), .SLICE_BITS(SLICE_BITS), .HI_W(HI_W), .LO_W(LO_W)
    ) u_delta (
        .addr (addr),
        .delta(delta)
    );

    ldt_merge #(
        .RES_W(RES_W), .HI_W(HI_W), .LO_W(LO_W)
    ) u_merge (
        .base (base),
        .delta(delta),
        .value(merged),
        .carry(carry)
    );

    // R1: the scaled base row never exceeds the entry it serves
    p_base_below_r1: assert property (@(posedge clk) disable iff (rst)
        ({1'b0, base, PASS_W'(0)} <= (RES_W + 1)'(ldt_pkg::ldt_ref(addr, ADDR_W, RES_W))));

    // R4: the narrow adder never carries out of the result width
    p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst) carry == 1'b0);

    // R3: rebuilt value matches the reference entry
    p_merge_exact_r3: assert property (@(posedge clk) disable iff (rst)
        merged == RES_W'(ldt_pkg::ldt_ref(addr, ADDR_W, RES_W)));

    if (REG_OUT) begin : g_reg
        logic [RES_W-1:0] result_q;

        always_ff @(posedge clk) begin
            if (rst) result_q <= '0;
            else     result_q <= merged;
        end

        assign result = result_q;

        // R5: the registered output shows the entry of the previously presented address
        p_latency_r5: assert property (@(posedge clk) disable iff (rst)
            !$past(rst) |-> result == RES_W'(ldt_pkg::ldt_ref($past(addr), ADDR_W, RES_W)));
    end else begin : g_comb
        assign result = merged;

        // R7: the combinational variant follows the address directly
        p_comb_exact_r7: assert property (@(posedge clk) disable iff (rst)
            result == RES_W'(ldt_pkg::ldt_ref(addr, ADDR_W, RES_W)));
    end
endmodule

// File: tb/ldt_rom_bench.sv
module ldt_rom_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] addr = '0;
    logic [7:0] res_reg;
    logic [7:0] res_comb;
    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    ldt_rom #(.REG_OUT(1'b1)) u_ldt_rom (
        .clk(clk), .rst(rst), .addr(addr), .result(res_reg));
    ldt_rom #(.REG_OUT(1'b0)) u_ldt_rom_comb (
        .clk(clk), .rst(rst), .addr(addr), .result(res_comb));

    function automatic int ref_val(int a);
        return 64 + (a * (768 - a)) / 1024;
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        addr = 8'd37;
        repeat (2) @(negedge clk);
        chk("R6 reset clears registered output", int'(res_reg), 0);
        chk("R7 comb output ignores reset", int'(res_comb), ref_val(37));
    endtask

    task automatic t_sweep();
        int prev;
        rst = 1'b0;
        @(negedge clk);
        prev = 37;
        for (int a = 0; a < 256; a++) begin
            chk("R5 registered output after edge", int'(res_reg), ref_val(prev));
            addr = 8'(a);
            #1;
            chk("R3 R7 comb lossless", int'(res_comb), ref_val(a));
            chk("R5 no change before edge", int'(res_reg), ref_val(prev));
            checks++;
            if (res_comb < 8'd64 || res_comb > 8'd191) begin
                failures++;
                $display("FAIL R4 result out of 64..191 actual=%0d expected=%0d",
                         res_comb, ref_val(a));
            end
            prev = a;
            @(negedge clk);
        end
        chk("R3 last address registered", int'(res_reg), ref_val(255));
    endtask

    task automatic t_slice_edges();
        int edges [8] = '{7, 8, 15, 16, 247, 248, 255, 0};
        foreach (edges[i]) begin
            addr = 8'(edges[i]);
            #1;
            chk("R1 slice edge comb", int'(res_comb), ref_val(edges[i]));
            @(negedge clk);
            chk("R1 slice edge registered", int'(res_reg), ref_val(edges[i]));
        end
    endtask

    task automatic t_hold();
        addr = 8'd200;
        @(negedge clk);
        for (int k = 0; k < 5; k++) begin
            chk("R5 held address stable", int'(res_reg), ref_val(200));
            @(negedge clk);
        end
    endtask

    task automatic t_mid_reset();
        addr = 8'd100;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R6 mid-run reset clears", int'(res_reg), 0);
        chk("R7 comb unaffected by reset", int'(res_comb), ref_val(100));
        rst = 1'b0;
        @(negedge clk);
        chk("R6 output resumes after reset", int'(res_reg), ref_val(100));
    endtask

    initial begin
        #(20 * 100000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset();
        t_sweep();
        t_slice_edges();
        t_hold();
        t_mid_reset();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule